// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a small 32-bit processor core that completes one instruction per clock cycle. On each rising edge it commits that instruction's register write, its data memory write and its next program counter. Between edges, a single combinational path fetches the instruction, decodes it, reads the operands, computes in the ALU and selects the next address. The core implements nine instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch on equal, and jump.

Instruction and data memories sit outside the core. Both are word-addressed arrays with an asynchronous read. The core presents the program counter as the instruction address and expects the instruction word back in the same cycle. For data it presents an address, write data and a write strobe, and takes the read data back combinationally. Every instruction is 32 bits. Bits 31:26 hold the opcode in all formats. In the register format, bits 25:21 are the first source, 20:16 the second source, 15:11 the destination and 5:0 the function code. The immediate format uses bits 15:0 as a signed 16-bit value. The jump format uses bits 25:0 as a word index.

Top module: `sc_core`

## Requirements
- R1: A load (opcode 0x23) writes the data word at address rs + sign-extended imm16 into register rt.
- R2: A store (opcode 0x2B) asserts the data write strobe for exactly its own cycle, with address rs + sign-extended imm16 and data equal to register rt. It writes no register.
- R3: While reset is low, the program counter is 0. Otherwise it advances by 4 after every instruction that is not a taken branch or a jump.
- R4: Opcode 0x00 with function 0x20 writes rs + rt into rd, and with function 0x22 writes rs − rt into rd (both wrap modulo 2^32).
- R5: Opcode 0x00 with function 0x24 writes rs AND rt into rd, and with function 0x25 writes rs OR rt into rd.
- R6: Opcode 0x00 with function 0x2A writes 1 into rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R7: Branch on equal (opcode 0x04) subtracts rt from rs. On a zero result the next PC is PC+4 + (sign-extended imm16 << 2), which covers negative displacements; otherwise the next PC is PC+4.
- R8: A jump (opcode 0x02) sets the next PC to {PC+4 bits 31:28, imm26, 2'b00}.
- R9: Register 0 always reads as 0. A write that targets it has no effect.
- R10: The 16-bit offset of a load or store is sign-extended, so 0xFFFC subtracts 4 from the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of PC and registers |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr |

## Verification
The test program holds one operand negative, so a set-less-than built on an unsigned compare writes 0 where 1 is expected, and a store written as a 0 in place of a sign-extended negative value shows up at once. A write to register 0 is followed by a store of register 0, which exposes a register file that lets the write through. The program then takes a forward branch and a jump, each of which skips a store; a mis-computed target or a condition that ignores the zero flag produces an unexpected or missing store. A store with a negative offset and a final branch to itself cover displacements that a zero-extended immediate would send far away.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;
   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_JUMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
   typedef enum logic [1:0] {AC_ADD, AC_SUB, AC_FUNCT} alu_class_e;

   typedef struct packed {
      logic       reg_write;
      logic       dst_is_rd;
      logic       src_is_imm;
      logic       mem_write;
      logic       wb_from_mem;
      logic       branch;
      logic       jump;
      alu_class_e alu_class;
   } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_cpu_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '0;
      ctrl.alu_class = AC_ADD;
      case (opcode)
         OP_RTYPE: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_is_rd = 1'b1;
            ctrl.alu_class = AC_FUNCT;
         end
         OP_LOAD: begin
            ctrl.reg_write   = 1'b1;
            ctrl.src_is_imm  = 1'b1;
            ctrl.wb_from_mem = 1'b1;
         end
         OP_STORE: begin
            ctrl.src_is_imm = 1'b1;
            ctrl.mem_write  = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch    = 1'b1;
            ctrl.alu_class = AC_SUB;
         end
         OP_JUMP: ctrl.jump = 1'b1;
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
   import sc_cpu_pkg::*;
(
   input  alu_class_e alu_class,
   input  logic [5:0] funct,
   output alu_op_e    alu_op
);
   always_comb begin
      case (alu_class)
         AC_SUB:   alu_op = ALU_SUB;
         AC_FUNCT: begin
            case (funct)
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_SLT:  alu_op = ALU_SLT;
               default: alu_op = ALU_ADD;
            endcase
         end
         default:  alu_op = ALU_ADD;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_cpu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   logic [W-1:0] diff;
   assign diff = a - b;

   always_comb begin
      case (op)
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (!rst_n)                          regs[i] <= '0;
            else if (we && wa == AW'(i))         regs[i] <= wd;
         end
      end
   end

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];

   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_a == '0) |-> (rd_a == '0)); // R9
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_cpu_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREG     = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata
);
   localparam int RAW = $clog2(NREG);

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: encoding fixes XLEN at 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc_core: 5-bit register fields need NREG of 32");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
   logic [XLEN-1:0] sext, rd_a, rd_b, alu_b, alu_y, wr_data;
   logic [5:0]      opcode, funct;
   logic [4:0]      rs, rt, rd, wr_addr;
   logic            alu_zero, take_br;
   ctrl_t           ctrl;
   alu_op_e         alu_op;

   assign opcode = imem_rdata[31:26];
   assign rs     = imem_rdata[25:21];
   assign rt     = imem_rdata[20:16];
   assign rd     = imem_rdata[15:11];
   assign funct  = imem_rdata[5:0];
   assign sext   = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

   sc_decode u_dec (.opcode(opcode), .ctrl(ctrl));
   sc_alu_ctrl u_aluc (.alu_class(ctrl.alu_class), .funct(funct), .alu_op(alu_op));

   assign wr_addr = ctrl.dst_is_rd ? rd : rt;
   assign wr_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

   sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra_a(rs[RAW-1:0]), .ra_b(rt[RAW-1:0]),
      .rd_a(rd_a), .rd_b(rd_b),
      .we(ctrl.reg_write), .wa(wr_addr[RAW-1:0]), .wd(wr_data)
   );

   assign alu_b = ctrl.src_is_imm ? sext : rd_b;

   sc_alu #(.W(XLEN)) u_alu (.a(rd_a), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero));

   assign pc_plus4   = pc_q + 32'd4;
   assign br_target  = pc_plus4 + {sext[XLEN-3:0], 2'b00};
   assign jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
   assign take_br    = ctrl.branch & alu_zero;

   always_comb begin
      if (ctrl.jump)    pc_next = jmp_target;
      else if (take_br) pc_next = br_target;
      else              pc_next = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= pc_next;
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rd_b;
   assign dmem_we    = ctrl.mem_write;

   AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_br && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R3
   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.branch && rd_a == rd_b) |=> (pc_q == $past(pc_q) + 32'd4 + {$past(sext[29:0]), 2'b00})); // R7
   AST_JUMP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.jump |=> (pc_q[27:2] == $past(imem_rdata[25:0]))); // R8
   AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> !ctrl.reg_write); // R2
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
   import sc_cpu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;
   logic [31:0] imem [32];
   logic [31:0] dmem [16];

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      string       req;
   } store_t;
   store_t exp_q[$];

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sc_core dut (
      .clk(clk), .rst_n(rst_n),
      .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
      .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
   );

   assign imem_rdata = imem[imem_addr[6:2]];
   assign dmem_rdata = dmem[dmem_addr[5:2]];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;

   function automatic logic [31:0] enc_r(logic [5:0] fn, int d, int s, int t);
      return {OP_RTYPE, s[4:0], t[4:0], d[4:0], 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int t, int s, int imm);
      return {op, s[4:0], t[4:0], imm[15:0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic expect_store(logic [31:0] a, logic [31:0] d, string req);
      store_t s;
      s.addr = a; s.data = d; s.req = req;
      exp_q.push_back(s);
   endtask

   // monitor: every store strobe must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && dmem_we) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R7/R8 unexpected store: actual addr %h data %h expected none",
                     dmem_addr, dmem_wdata);
         end else begin
            store_t s;
            s = exp_q.pop_front();
            check({s.req, " addr"}, dmem_addr, s.addr);
            check({s.req, " data"}, dmem_wdata, s.data);
         end
      end
   end

   initial begin
      bit reached;
      for (int i = 0; i < 32; i++) imem[i] = 32'h0;
      for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
      dmem[0] = 32'd5;
      dmem[1] = 32'hFFFF_FFFD;
      dmem[2] = 32'd64;

      imem[0]  = enc_i(OP_LOAD, 1, 0, 0);
      imem[1]  = enc_i(OP_LOAD, 2, 0, 4);
      imem[2]  = enc_r(FN_ADD, 3, 1, 2);
      imem[3]  = enc_i(OP_STORE, 3, 0, 16);
      imem[4]  = enc_r(FN_SUB, 4, 1, 2);
      imem[5]  = enc_i(OP_STORE, 4, 0, 20);
      imem[6]  = enc_r(FN_AND, 5, 1, 2);
      imem[7]  = enc_i(OP_STORE, 5, 0, 24);
      imem[8]  = enc_r(FN_OR, 6, 1, 2);
      imem[9]  = enc_i(OP_STORE, 6, 0, 28);
      imem[10] = enc_r(FN_SLT, 7, 2, 1);
      imem[11] = enc_i(OP_STORE, 7, 0, 32);
      imem[12] = enc_r(FN_SLT, 8, 1, 2);
      imem[13] = enc_i(OP_STORE, 8, 0, 36);
      imem[14] = enc_r(FN_ADD, 0, 1, 1);
      imem[15] = enc_i(OP_STORE, 0, 0, 40);
      imem[16] = enc_i(OP_BEQ, 2, 1, 1);
      imem[17] = enc_i(OP_STORE, 1, 0, 44);
      imem[18] = enc_i(OP_BEQ, 1, 1, 1);
      imem[19] = enc_i(OP_STORE, 2, 0, 48);
      imem[20] = enc_i(OP_LOAD, 9, 0, 8);
      imem[21] = enc_i(OP_STORE, 3, 9, -4);
      imem[22] = {OP_JUMP, 26'd24};
      imem[23] = enc_i(OP_STORE, 2, 0, 52);
      imem[24] = enc_i(OP_STORE, 2, 0, 56);
      imem[25] = enc_i(OP_BEQ, 0, 0, -1);

      expect_store(32'd16, 32'd2,          "R1 R4 add");
      expect_store(32'd20, 32'd8,          "R4 sub");
      expect_store(32'd24, 32'd5,          "R5 and");
      expect_store(32'd28, 32'hFFFF_FFFD,  "R5 or");
      expect_store(32'd32, 32'd1,          "R6 slt true");
      expect_store(32'd36, 32'd0,          "R6 slt false");
      expect_store(32'd40, 32'd0,          "R9 r0 write ignored");
      expect_store(32'd44, 32'd5,          "R7 beq not taken");
      expect_store(32'd60, 32'd2,          "R10 negative offset");
      expect_store(32'd56, 32'hFFFF_FFFD,  "R2 R8 after jump");

      repeat (3) @(negedge clk);
      check("R3 pc at reset", imem_addr, 32'h0);
      rst_n = 1'b1;

      reached = 1'b0;
      for (int c = 0; c < 400 && !reached; c++) begin
         @(negedge clk);
         if (imem_addr == 32'd100) reached = 1'b1;
      end
      if (!reached) begin
         checks++; errors++;
         $display("FAIL watchdog: actual pc %h expected 00000064", imem_addr);
      end
      repeat (5) @(negedge clk);
      check("R7 backward branch holds pc", imem_addr, 32'd100);
      check("R2 R7 R8 pending stores", 32'(exp_q.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule